// File: doc/BRIEF.md
# MSB-first bit search unit

This block is a small memory-mapped helper that sits beside a 32-bit processor and locates a target bit inside a data word, scanning from the most significant end toward bit 0. Software picks the kind of search by choosing which of three operand registers it writes. One register looks for the first cleared bit. One looks for the first set bit. The third looks for the first point where the word's value changes from its top bit. The position found can be read back on the next cycle from a single result register.

Positions are counted from the top of the word: bit 31 reports 0 and bit 0 reports 31. When the word holds no qualifying bit, the result is 32. Each operand register keeps the last word written to it and can be read back. The interface is a single-cycle synchronous register port. Writes are clocked, and read data follows the address combinationally.

Top module: `msb_bitscan`

## Requirements
- R1: A write to address 0 latches the operand and selects zero search. The result is the position, counted from the MSB, of the highest-numbered 0 bit (for example 0xFFFF0000 gives 16).
- R2: A write to address 1 latches the operand and selects one search. The result is the position, counted from the MSB, of the highest-numbered 1 bit (for example 0x00100000 gives 11).
- R3: A write to address 2 latches the operand and selects change search. The result is the position, counted from the MSB, of the highest-numbered bit whose value differs from bit 31. The MSB itself is never reported, so a found position is at least 1.
- R4: When no bit qualifies, the result is 32. This covers an all-ones word in zero search, an all-zeros word in one search, and a uniform word in change search.
- R5: The result register shows the new position on the clock edge that takes the write. It holds its value while no mode write occurs.
- R6: Reading address 0, 1 or 2 returns the word last written to that address. A write to one operand address leaves the other two unchanged.
- R7: Reading address 3 returns the result zero-extended to 32 bits. Writes to address 3 change neither the result nor any operand.
- R8: After reset, all three operands read 0 and the result reads 0, which is the value zero search gives for an all-zero word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wen | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Register address: 0 zero, 1 one, 2 change, 3 result |
| wdata | input | 32 | Operand data for writes |
| rdata | output | 32 | Read data for the addressed register |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a 2-bit address. This means the real word-edge cases are exercised directly. These include a target at bit 31, a target at bit 0, a change at the position just below the MSB, and the no-match value of 32, which needs the sixth result bit. With a full 32-bit operand, each mode also meets patterns whose target lies deep in the low half of the word. This exposes any early exit or reversed priority in the scan.

// File: rtl/bitscan_pkg.sv
package bitscan_pkg;

  // Search kinds; the encoding equals the operand register address.
  typedef enum logic [1:0] {
    SCAN_ZERO   = 2'd0,
    SCAN_ONE    = 2'd1,
    SCAN_CHANGE = 2'd2
  } scan_mode_e;

  localparam int NUM_MODES = 3;

endpackage

// File: rtl/bitscan_decode.sv
module bitscan_decode
  import bitscan_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_MODES-1:0] wr_sel,
  output logic              wr_any,
  output scan_mode_e        wr_mode
);

  always_comb begin
    wr_sel  = '0;
    wr_mode = SCAN_ZERO;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (wen && (addr == ADDR_W'(m))) begin
        wr_sel[m] = 1'b1;
        wr_mode   = scan_mode_e'(m);
      end
    end
  end

  assign wr_any = |wr_sel;

endmodule

// File: rtl/bitscan_opregs.sv
module bitscan_opregs
  import bitscan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_MODES-1:0] wr_sel,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    operand [NUM_MODES]
);

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_op
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         operand[g] <= '0;
      else if (wr_sel[g]) operand[g] <= wdata;
    end
  end

endmodule

// File: rtl/bitscan_core.sv
module bitscan_core
  import bitscan_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int RES_W = $clog2(DATA_W + 1)
) (
  input  scan_mode_e        mode,
  input  logic [DATA_W-1:0] word,
  output logic [RES_W-1:0]  pos,
  output logic              found
);

  // Position, counted from the MSB, of the highest set bit; DATA_W if none.
  function automatic logic [RES_W-1:0] top_set_pos(input logic [DATA_W-1:0] v);
    logic [RES_W-1:0] p;
    p = RES_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (v[i]) p = RES_W'(DATA_W - 1 - i);
    end
    return p;
  endfunction

  // Marks each bit that differs from its upper neighbour; the MSB never marks.
  function automatic logic [DATA_W-1:0] edge_marks(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] e;
    e = '0;
    for (int i = 0; i < DATA_W - 1; i++) e[i] = w[i] ^ w[i+1];
    return e;
  endfunction

  logic [DATA_W-1:0] target;

  always_comb begin
    unique case (mode)
      SCAN_ONE:    target = word;
      SCAN_CHANGE: target = edge_marks(word);
      default:     target = ~word;
    endcase
  end

  assign pos   = top_set_pos(target);
  assign found = |target;

endmodule

// File: rtl/msb_bitscan.sv
module msb_bitscan
  import bitscan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  localparam int RES_W = $clog2(DATA_W + 1),
  localparam int RES_ADDR = NUM_MODES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [NUM_MODES-1:0] wr_sel;
  logic                 wr_any;
  scan_mode_e           wr_mode;
  logic [DATA_W-1:0]    operand [NUM_MODES];
  logic [RES_W-1:0]     scan_pos;
  logic                 scan_hit;
  logic [RES_W-1:0]     result_q;
  scan_mode_e           mode_q;

  bitscan_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wen     (wen),
    .addr    (addr),
    .wr_sel  (wr_sel),
    .wr_any  (wr_any),
    .wr_mode (wr_mode)
  );

  bitscan_opregs #(.DATA_W(DATA_W)) u_ops (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wdata   (wdata),
    .operand (operand)
  );

  // The search works on the incoming word so the result lands with the write.
  bitscan_core #(.DATA_W(DATA_W)) u_core (
    .mode  (wr_mode),
    .word  (wdata),
    .pos   (scan_pos),
    .found (scan_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      mode_q   <= SCAN_ZERO;
    end else if (wr_any) begin
      result_q <= scan_pos;
      mode_q   <= wr_mode;
    end
  end

  always_comb begin
    rdata = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (addr == ADDR_W'(m)) rdata = operand[m];
    end
    if (addr == ADDR_W'(RES_ADDR)) rdata = DATA_W'(result_q);
  end

endmodule

// File: rtl/bitscan_chk.sv
module bitscan_chk
  import bitscan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  localparam int RES_W = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wen,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [RES_W-1:0]  result_q,
  input scan_mode_e        mode_q
);

  a_r1_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr == ADDR_W'(0) && !wdata[DATA_W-1]) |=> result_q == '0);

  a_r2_one_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr == ADDR_W'(1) && wdata[DATA_W-1]) |=> result_q == '0);

  a_r3_change_never_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SCAN_CHANGE) |-> result_q != '0);

  a_r4_no_match_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr == ADDR_W'(0) && (&wdata)) |=> result_q == RES_W'(DATA_W));

  a_r4_no_match_one: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr == ADDR_W'(1) && !(|wdata)) |=> result_q == RES_W'(DATA_W));

  a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
    result_q <= RES_W'(DATA_W));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> $stable(result_q));

  a_r7_result_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && addr == ADDR_W'(3)) |=> ($stable(result_q) && $stable(mode_q)));

endmodule

bind msb_bitscan bitscan_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wen      (wen),
  .addr     (addr),
  .wdata    (wdata),
  .result_q (result_q),
  .mode_q   (mode_q)
);

// File: tb/msb_bitscan_tb_top.sv
`timescale 1ns/1ps
module msb_bitscan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wen = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msb_bitscan dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wen   (wen),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  // Independent model: walk down from bit 31 and test each bit against the rule.
  function automatic int model(input int mode, input logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      if (mode == 0 && w[i] == 1'b0) return 31 - i;
      if (mode == 1 && w[i] == 1'b1) return 31 - i;
      if (mode == 2 && i != 31 && w[i] != w[31]) return 31 - i;
    end
    return 32;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wen = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic search(input string req, input int mode, input logic [31:0] w, input int exp);
    logic [31:0] r;
    wr(2'(mode), w);
    rd(2'd3, r);
    check(req, r, 32'(exp));
    check(req, r, 32'(model(mode, w)));
  endtask

  task automatic t_reset;
    logic [31:0] r;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      check("R8", r, 32'd0);
    end
  endtask

  task automatic t_zero;
    search("R1", 0, 32'h0000_0000, 0);
    search("R1", 0, 32'hFFFF_0000, 16);
    search("R1", 0, 32'hFFFF_FFFE, 31);
    search("R1", 0, 32'hBFFF_FFFF, 1);
  endtask

  task automatic t_one;
    search("R2", 1, 32'h8000_0000, 0);
    search("R2", 1, 32'h0010_0000, 11);
    search("R2", 1, 32'h0000_0001, 31);
    search("R2", 1, 32'h0000_7F00, 17);
  endtask

  task automatic t_change;
    search("R3", 2, 32'h4000_0000, 1);
    search("R3", 2, 32'h8000_0000, 1);
    search("R3", 2, 32'hC000_0000, 2);
    search("R3", 2, 32'h0000_0001, 31);
    search("R3", 2, 32'hFFFF_FFFE, 31);
    search("R3", 2, 32'hFFF0_FFFF, 12);
  endtask

  task automatic t_nomatch;
    search("R4", 0, 32'hFFFF_FFFF, 32);
    search("R4", 1, 32'h0000_0000, 32);
    search("R4", 2, 32'h0000_0000, 32);
    search("R4", 2, 32'hFFFF_FFFF, 32);
  endtask

  task automatic t_hold;
    logic [31:0] r;
    wr(2'd1, 32'h0008_0000);
    rd(2'd3, r);
    check("R5", r, 32'd12);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      addr = 2'(k % 3);
      wdata = 32'hFFFF_FFFF;
      rd(2'd3, r);
      check("R5", r, 32'd12);
    end
  endtask

  task automatic t_readback;
    logic [31:0] r;
    wr(2'd0, 32'h1234_5678);
    wr(2'd1, 32'h9ABC_DEF0);
    wr(2'd2, 32'h0F0F_00FF);
    rd(2'd0, r); check("R6", r, 32'h1234_5678);
    rd(2'd1, r); check("R6", r, 32'h9ABC_DEF0);
    rd(2'd2, r); check("R6", r, 32'h0F0F_00FF);
    wr(2'd1, 32'h0000_0003);
    rd(2'd0, r); check("R6", r, 32'h1234_5678);
    rd(2'd2, r); check("R6", r, 32'h0F0F_00FF);
  endtask

  task automatic t_result_ro;
    logic [31:0] r;
    wr(2'd0, 32'hFF00_0000);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, r); check("R7", r, 32'd8);
    rd(2'd0, r); check("R7", r, 32'hFF00_0000);
    wr(2'd3, 32'h0000_0000);
    rd(2'd3, r); check("R7", r, 32'd8);
  endtask

  initial begin
    #(8 * 150_000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_one();
    t_change();
    t_nomatch();
    t_hold();
    t_readback();
    t_result_ro();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule